// File: doc/BRIEF.md
# Flash Region Protection Checker

This block sits in front of a two-bank flash array and decides, for each request, whether the request may proceed. A request is a data read, an instruction fetch, a double-word write, a page erase or a mass erase. Each physical bank carries one execute-only region and two write-protect areARS. The execute-only region is given in 8-byte double-word units and includes both of its end points. Each write-protect area is given in 2 KB page units and covers from its first page through its last page.

The flash window is 1 MB. Physical bank 1 normally answers the lower 512 KB and physical bank 2 the upper 512 KB. A swap input exchanges the two halves. The checker works out the physical bank first and then applies that bank's own register set.

The grant is combinational in the request cycle. A refused read sets a sticky read-error flag, and a refused write or erase sets a sticky write-protection-error flag. Either flag is cleared by a one-cycle clear strobe.

Top module: `flprot_guard`

## Requirements
- R1: The physical bank equals req_addr[19] XOR swap_banks, where 0 is bank 1 and 1 is bank 2. The bank offset is req_addr[18:0], and only the selected bank's register set is applied.
- R2: A data read (req_op=1, req_ifetch=0) whose double-word offset lies in the execute-only range is refused. The read-error flag is then set after the next rising clock edge.
- R3: An instruction fetch (req_op=1, req_ifetch=1) is always granted and raises no flag. A read of either kind is never refused because of a write-protect area.
- R4: The execute-only range covers double-word offsets (offset>>3) from lo through hi, with both ends included. For example, lo=0xC5F0 and hi=0xE000 protect byte offsets 0x62F80 through 0x70007.
- R5: A write (req_op=2) is refused, and sets the write-protection-error flag, when its double word is execute-only or when its page (offset>>11) lies in write-protect area A or B. Area A sits in bits [7:0] of the start and end registers and area B in bits [15:8]; each area covers pages lo..hi, both included.
- R6: A page erase (req_op=3) is refused, and sets the write-protection-error flag, when its page overlaps the execute-only range, including the partly covered pages at each end, or lies in a write-protect area. With the R4 example, pages 0xC5 through 0xE0 are refused.
- R7: A mass erase (req_op=4) is refused, and sets the write-protection-error flag, when the execute-only region of either bank is non-empty. The request address has no effect on this decision.
- R8: A region or area whose start value is greater than its end value is empty and protects nothing.
- R9: Both flags stay set until their clear strobe (clr_rd_err or clr_wp_err) is sampled high at a rising edge. A set in the same cycle as a clear wins.
- R10: Reset clears both flags. grant is high only while req_valid is high. Op codes 0 and 5 to 7 are never granted and raise no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | 1 read, 2 write, 3 page erase, 4 mass erase |
| req_addr | input | 20 | Byte offset within the flash window |
| req_ifetch | input | 1 | Read comes from the instruction-fetch side |
| swap_banks | input | 1 | Exchange the two bank halves |
| xo_lo_b1 | input | 16 | Bank 1 execute-only first double word |
| xo_hi_b1 | input | 16 | Bank 1 execute-only last double word |
| xo_lo_b2 | input | 16 | Bank 2 execute-only first double word |
| xo_hi_b2 | input | 16 | Bank 2 execute-only last double word |
| wp_lo_b1 | input | 16 | Bank 1 write-protect first pages, area B in [15:8] and area A in [7:0] |
| wp_hi_b1 | input | 16 | Bank 1 write-protect last pages, same layout |
| wp_lo_b2 | input | 16 | Bank 2 write-protect first pages |
| wp_hi_b2 | input | 16 | Bank 2 write-protect last pages |
| clr_rd_err | input | 1 | Clear strobe for the read-error flag |
| clr_wp_err | input | 1 | Clear strobe for the write-protection-error flag |
| grant | output | 1 | Request allowed this cycle |
| rd_err | output | 1 | Sticky read-error flag |
| wp_err | output | 1 | Sticky write-protection-error flag |

## Verification
The assertions assume that the configuration registers are stable during a request. They also assume that req_op is a clean 3-bit code while req_valid is high, and that the clear strobes are either level, since each one is sampled only at a rising edge. The bench changes the configuration only between batches of requests, while req_valid is low. It drives every input at the falling edge, so each request and each strobe is seen at exactly one rising edge. Addresses are drawn either near the configured region bounds or uniformly over the window, so that both the boundary decisions and the plain cases occur.

// File: rtl/flprot_pkg.sv
package flprot_pkg;
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_READ   = 3'd1,
    OP_WRITE  = 3'd2,
    OP_PERASE = 3'd3,
    OP_MERASE = 3'd4
  } flop_e;
endpackage

// File: rtl/flprot_bank_rules.sv
module flprot_bank_rules #(
  parameter int BANK_AW = 19,
  parameter int DW_LG   = 3,
  parameter int PAGE_LG = 11,
  parameter int N_WP    = 2,
  localparam int DW_W   = BANK_AW - DW_LG,
  localparam int PG_W   = BANK_AW - PAGE_LG,
  localparam int SH     = PAGE_LG - DW_LG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DW_W-1:0]      dw,
  input  logic [DW_W-1:0]      xo_lo,
  input  logic [DW_W-1:0]      xo_hi,
  input  logic [N_WP*PG_W-1:0] wp_lo,
  input  logic [N_WP*PG_W-1:0] wp_hi,
  output logic                 xo_hit_dw,
  output logic                 xo_hit_page,
  output logic                 wp_hit_page,
  output logic                 xo_defined
);
  logic [PG_W-1:0] page;
  logic [N_WP-1:0] area_hit;

  function automatic logic dw_inside(input logic [DW_W-1:0] d,
                                     input logic [DW_W-1:0] lo,
                                     input logic [DW_W-1:0] hi);
    return (lo <= hi) && (d >= lo) && (d <= hi);
  endfunction

  function automatic logic page_touches(input logic [PG_W-1:0] p,
                                        input logic [DW_W-1:0] lo,
                                        input logic [DW_W-1:0] hi);
    logic [PG_W-1:0] plo, phi;
    plo = lo[DW_W-1:SH];
    phi = hi[DW_W-1:SH];
    return (lo <= hi) && (p >= plo) && (p <= phi);
  endfunction

  function automatic logic page_inside(input logic [PG_W-1:0] p,
                                       input logic [PG_W-1:0] lo,
                                       input logic [PG_W-1:0] hi);
    return (lo <= hi) && (p >= lo) && (p <= hi);
  endfunction

  assign page        = dw[DW_W-1:SH];
  assign xo_defined  = (xo_lo <= xo_hi);
  assign xo_hit_dw   = dw_inside(dw, xo_lo, xo_hi);
  assign xo_hit_page = page_touches(page, xo_lo, xo_hi);

  for (genvar a = 0; a < N_WP; a++) begin : g_area
    assign area_hit[a] = page_inside(page, wp_lo[a*PG_W +: PG_W],
                                     wp_hi[a*PG_W +: PG_W]);
  end
  assign wp_hit_page = |area_hit;

  // R8: an empty execute-only region never matches anything
  a_r8_empty_xo: assert property (@(posedge clk) disable iff (!rst_n)
    (xo_lo > xo_hi) |-> (!xo_hit_dw && !xo_hit_page));
  // R6: a double-word hit always lies on a page that the region touches
  a_r6_page_covers_dw: assert property (@(posedge clk) disable iff (!rst_n)
    xo_hit_dw |-> xo_hit_page);
endmodule

// File: rtl/flprot_decide.sv
module flprot_decide
  import flprot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic       req_ifetch,
  input  logic       xo_dw,
  input  logic       xo_pg,
  input  logic       wp_pg,
  input  logic       any_xo,
  output logic       grant,
  output logic       set_rd,
  output logic       set_wp
);
  logic blocked, known;

  always_comb begin
    blocked = 1'b0;
    known   = 1'b1;
    set_rd  = 1'b0;
    set_wp  = 1'b0;
    unique case (flop_e'(req_op))
      OP_READ: begin
        blocked = !req_ifetch && xo_dw;
        set_rd  = req_valid && blocked;
      end
      OP_WRITE: begin
        blocked = xo_dw || wp_pg;
        set_wp  = req_valid && blocked;
      end
      OP_PERASE: begin
        blocked = xo_pg || wp_pg;
        set_wp  = req_valid && blocked;
      end
      OP_MERASE: begin
        blocked = any_xo;
        set_wp  = req_valid && blocked;
      end
      default: known = 1'b0;
    endcase
    grant = req_valid && known && !blocked;
  end

  // R10: a refusal raises at most one flag, and a grant raises none
  a_r10_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_rd, set_wp}));
  a_r10_grant_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !(set_rd || set_wp));
endmodule

// File: rtl/flprot_err_flags.sv
module flprot_err_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic set_rd,
  input  logic set_wp,
  input  logic clr_rd,
  input  logic clr_wp,
  output logic rd_err,
  output logic wp_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_err <= 1'b0;
      wp_err <= 1'b0;
    end else begin
      if (set_rd)      rd_err <= 1'b1;
      else if (clr_rd) rd_err <= 1'b0;
      if (set_wp)      wp_err <= 1'b1;
      else if (clr_wp) wp_err <= 1'b0;
    end
  end

  a_r9_rd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !clr_rd) |=> rd_err);
  a_r9_wp_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_err && !clr_wp) |=> wp_err);
  a_r9_rd_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rd && !set_rd) |=> !rd_err);
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_wp |=> wp_err);
endmodule

// File: rtl/flprot_guard.sv
module flprot_guard
  import flprot_pkg::*;
#(
  parameter int BANK_AW = 19,
  parameter int DW_LG   = 3,
  parameter int PAGE_LG = 11,
  parameter int N_WP    = 2,
  localparam int ADDR_W = BANK_AW + 1,
  localparam int DW_W   = BANK_AW - DW_LG,
  localparam int PG_W   = BANK_AW - PAGE_LG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [2:0]           req_op,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_ifetch,
  input  logic                 swap_banks,
  input  logic [DW_W-1:0]      xo_lo_b1,
  input  logic [DW_W-1:0]      xo_hi_b1,
  input  logic [DW_W-1:0]      xo_lo_b2,
  input  logic [DW_W-1:0]      xo_hi_b2,
  input  logic [N_WP*PG_W-1:0] wp_lo_b1,
  input  logic [N_WP*PG_W-1:0] wp_hi_b1,
  input  logic [N_WP*PG_W-1:0] wp_lo_b2,
  input  logic [N_WP*PG_W-1:0] wp_hi_b2,
  input  logic                 clr_rd_err,
  input  logic                 clr_wp_err,
  output logic                 grant,
  output logic                 rd_err,
  output logic                 wp_err
);
  logic [DW_W-1:0]      xo_lo [2];
  logic [DW_W-1:0]      xo_hi [2];
  logic [N_WP*PG_W-1:0] wp_lo [2];
  logic [N_WP*PG_W-1:0] wp_hi [2];
  logic [1:0]           hit_dw, hit_pg, hit_wp, defined;
  logic                 phys_bank;
  logic [DW_W-1:0]      dw;
  logic                 sel_xo_dw, sel_xo_pg, sel_wp_pg, any_xo;
  logic                 set_rd, set_wp;
  logic [DW_LG-1:0]     unused_byte_lane;

  assign xo_lo[0] = xo_lo_b1;  assign xo_hi[0] = xo_hi_b1;
  assign xo_lo[1] = xo_lo_b2;  assign xo_hi[1] = xo_hi_b2;
  assign wp_lo[0] = wp_lo_b1;  assign wp_hi[0] = wp_hi_b1;
  assign wp_lo[1] = wp_lo_b2;  assign wp_hi[1] = wp_hi_b2;

  // R1: physical bank from the top address bit and the swap input
  assign phys_bank        = req_addr[ADDR_W-1] ^ swap_banks;
  assign dw               = req_addr[BANK_AW-1:DW_LG];
  assign unused_byte_lane = req_addr[DW_LG-1:0];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    flprot_bank_rules #(
      .BANK_AW(BANK_AW), .DW_LG(DW_LG), .PAGE_LG(PAGE_LG), .N_WP(N_WP)
    ) u_rules (
      .clk        (clk),
      .rst_n      (rst_n),
      .dw         (dw),
      .xo_lo      (xo_lo[b]),
      .xo_hi      (xo_hi[b]),
      .wp_lo      (wp_lo[b]),
      .wp_hi      (wp_hi[b]),
      .xo_hit_dw  (hit_dw[b]),
      .xo_hit_page(hit_pg[b]),
      .wp_hit_page(hit_wp[b]),
      .xo_defined (defined[b])
    );
  end

  assign sel_xo_dw = hit_dw[phys_bank];
  assign sel_xo_pg = hit_pg[phys_bank];
  assign sel_wp_pg = hit_wp[phys_bank];
  assign any_xo    = |defined;

  flprot_decide u_decide (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ifetch(req_ifetch),
    .xo_dw     (sel_xo_dw),
    .xo_pg     (sel_xo_pg),
    .wp_pg     (sel_wp_pg),
    .any_xo    (any_xo),
    .grant     (grant),
    .set_rd    (set_rd),
    .set_wp    (set_wp)
  );

  flprot_err_flags u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_rd(set_rd),
    .set_wp(set_wp),
    .clr_rd(clr_rd_err),
    .clr_wp(clr_wp_err),
    .rd_err(rd_err),
    .wp_err(wp_err)
  );

  a_r10_grant_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> req_valid);
  a_r2_data_read_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1 && !req_ifetch && sel_xo_dw) |-> !grant);
  a_r2_read_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1 && !req_ifetch && sel_xo_dw) |=> rd_err);
  a_r3_fetch_granted: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd1 && req_ifetch) |-> grant);
  a_r7_mass_erase: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd4 && any_xo) |-> !grant);
  a_r5_write_xo: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_op == 3'd2 && sel_xo_dw) |=> wp_err);
endmodule

// File: tb/flprot_guard_tb_top.sv
`timescale 1ns/1ps
module flprot_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [19:0] req_addr = '0;
  logic        req_ifetch = 1'b0;
  logic        swap_banks = 1'b0;
  logic [15:0] xo_lo_b1, xo_hi_b1, xo_lo_b2, xo_hi_b2;
  logic [15:0] wp_lo_b1, wp_hi_b1, wp_lo_b2, wp_hi_b2;
  logic        clr_rd_err = 1'b0, clr_wp_err = 1'b0;
  logic        grant, rd_err, wp_err;

  int checks = 0, errors = 0;
  bit exp_rd = 0, exp_wp = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flprot_guard dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_ifetch(req_ifetch), .swap_banks(swap_banks),
    .xo_lo_b1(xo_lo_b1), .xo_hi_b1(xo_hi_b1), .xo_lo_b2(xo_lo_b2),
    .xo_hi_b2(xo_hi_b2), .wp_lo_b1(wp_lo_b1), .wp_hi_b1(wp_hi_b1),
    .wp_lo_b2(wp_lo_b2), .wp_hi_b2(wp_hi_b2), .clr_rd_err(clr_rd_err),
    .clr_wp_err(clr_wp_err), .grant(grant), .rd_err(rd_err), .wp_err(wp_err)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // byte-span model of the execute-only region
  function automatic bit xo_bytes(input int lo, input int hi, input int b0, input int b1);
    if (lo > hi) return 0;
    return (b1 >= lo * 8) && (b0 <= hi * 8 + 7);
  endfunction

  function automatic bit wp_byte(input int lo, input int hi, input int b);
    if (lo > hi) return 0;
    return (b >= lo * 2048) && (b < (hi + 1) * 2048);
  endfunction

  // returns {grant, set_rd, set_wp}
  function automatic bit [2:0] model(input int op, input int addr, input bit fetch, input bit swp);
    int bank, off, xl, xh, pg0, lo16, hi16;
    bit xo_b, xo_p, wp_p, any;
    bank = ((addr >> 19) & 1) ^ int'(swp);
    off  = addr & 32'h7FFFF;
    xl   = (bank == 0) ? int'(xo_lo_b1) : int'(xo_lo_b2);
    xh   = (bank == 0) ? int'(xo_hi_b1) : int'(xo_hi_b2);
    lo16 = (bank == 0) ? int'(wp_lo_b1) : int'(wp_lo_b2);
    hi16 = (bank == 0) ? int'(wp_hi_b1) : int'(wp_hi_b2);
    pg0  = off & ~32'h7FF;
    xo_b = xo_bytes(xl, xh, off, off);
    xo_p = xo_bytes(xl, xh, pg0, pg0 + 2047);
    wp_p = wp_byte(lo16 & 255, hi16 & 255, off) || wp_byte(lo16 >> 8, hi16 >> 8, off);
    any  = (xo_lo_b1 <= xo_hi_b1) || (xo_lo_b2 <= xo_hi_b2);
    case (op)
      1: return (!fetch && xo_b) ? 3'b010 : 3'b100;
      2: return (xo_b || wp_p) ? 3'b001 : 3'b100;
      3: return (xo_p || wp_p) ? 3'b001 : 3'b100;
      4: return any ? 3'b001 : 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  task automatic do_req(input string req, input int op, input int addr,
                        input bit fetch, input bit cr, input bit cw);
    bit [2:0] e;
    @(negedge clk);
    req_valid = 1'b1; req_op = op[2:0]; req_addr = addr[19:0];
    req_ifetch = fetch; clr_rd_err = cr; clr_wp_err = cw;
    #1;
    e = model(op, addr, fetch, swap_banks);
    check({req, " grant"}, int'(grant), int'(e[2]));
    @(posedge clk);
    exp_rd = e[1] ? 1'b1 : (cr ? 1'b0 : exp_rd);
    exp_wp = e[0] ? 1'b1 : (cw ? 1'b0 : exp_wp);
    #1;
    check({req, " rd_err"}, int'(rd_err), int'(exp_rd));
    check({req, " wp_err"}, int'(wp_err), int'(exp_wp));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; clr_rd_err = 1'b0; clr_wp_err = 1'b0;
  endtask

  function automatic logic [15:0] rnd_region(output logic [15:0] hi);
    logic [15:0] lo;
    lo = 16'($urandom);
    if ($urandom_range(0, 3) == 0) hi = lo - 16'd1 - 16'($urandom_range(0, 100));
    else hi = lo + 16'($urandom_range(0, 6000));
    if (hi < lo && $urandom_range(0, 3) != 0) hi = 16'hFFFF;
    return lo;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h0F1A_5EED));
    xo_lo_b1 = 16'hC5F0; xo_hi_b1 = 16'hE000;
    xo_lo_b2 = 16'hFFFF; xo_hi_b2 = 16'h0000;
    wp_lo_b1 = 16'hFF10; wp_hi_b1 = 16'h0012;
    wp_lo_b2 = 16'h2221; wp_hi_b2 = 16'h2221;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset grant", int'(grant), 0);
    check("R10 reset rd_err", int'(rd_err), 0);
    check("R10 reset wp_err", int'(wp_err), 0);
    @(negedge clk); rst_n = 1'b1;

    // R4 inclusive bounds, R2 data read
    do_req("R4 below start", 1, 32'h62F78, 0, 0, 0);
    do_req("R2 R4 start dw", 1, 32'h62F80, 0, 0, 0);
    do_req("R4 end dw", 1, 32'h70007, 0, 0, 0);
    do_req("R4 past end", 1, 32'h70008, 0, 0, 0);
    // R9 sticky, then clear
    do_req("R9 sticky", 1, 32'h00000, 0, 0, 0);
    do_req("R9 clear", 1, 32'h00000, 0, 1, 0);
    // R3 fetch
    do_req("R3 fetch xo", 1, 32'h68000, 1, 0, 0);
    do_req("R3 read in wp", 1, 32'h08800, 0, 0, 0);
    // R6 page erase edges
    do_req("R6 page C4", 3, 32'h627F8, 0, 0, 0);
    do_req("R6 page C5", 3, 32'h62800, 0, 0, 0);
    do_req("R6 page E0", 3, 32'h707F8, 0, 0, 0);
    do_req("R6 page E1", 3, 32'h70800, 0, 0, 1);
    // R5 write: xo and WRP area A pages 0x10..0x12
    do_req("R5 write xo", 2, 32'h63000, 0, 0, 1);
    do_req("R5 write page 0F", 2, 32'h07FF8, 0, 0, 1);
    do_req("R5 write page 12", 2, 32'h097F8, 0, 0, 0);
    do_req("R5 write page 13", 2, 32'h09800, 0, 0, 1);
    // R8 empty area B of bank1 and empty xo bank2
    do_req("R8 empty area", 2, 32'h7F800, 0, 0, 0);
    do_req("R8 empty xo b2", 1, 32'hE3000, 0, 0, 0);
    // R1 swap: upper half becomes bank 1
    swap_banks = 1'b1;
    do_req("R1 swapped hit", 1, 32'hE3000, 0, 1, 0);
    do_req("R1 swapped miss", 1, 32'h63000, 0, 1, 0);
    do_req("R1 b2 area page 21", 2, 32'h10800, 0, 0, 1);
    swap_banks = 1'b0;
    // R7 mass erase, R10 reserved ops
    do_req("R7 mass blocked", 4, 32'h12345, 0, 0, 1);
    do_req("R10 op0", 0, 32'h00000, 0, 0, 1);
    do_req("R10 op6", 6, 32'h63000, 0, 0, 0);
    idle();
    xo_lo_b1 = 16'h0001; xo_hi_b1 = 16'h0000;
    do_req("R7 mass allowed", 4, 32'hFFFFF, 0, 0, 0);

    // random batches
    for (int batch = 0; batch < 15; batch++) begin
      idle();
      xo_lo_b1 = rnd_region(xo_hi_b1);
      xo_lo_b2 = rnd_region(xo_hi_b2);
      wp_lo_b1 = 16'($urandom); wp_hi_b1 = wp_lo_b1 + 16'h0303;
      wp_lo_b2 = 16'($urandom); wp_hi_b2 = 16'($urandom);
      swap_banks = 1'($urandom);
      for (int k = 0; k < 200; k++) begin
        int a, op;
        op = $urandom_range(0, 7);
        if ($urandom_range(0, 1) == 0) begin
          a = ($urandom_range(0, 1) ? int'(xo_lo_b1) : int'(xo_hi_b1)) * 8
              + $urandom_range(0, 4095) - 2048;
          a = (a & 32'h7FFFF) | ($urandom_range(0, 1) << 19);
        end else a = $urandom_range(0, 32'hFFFFF);
        do_req("R5 R6 random", op, a, 1'($urandom_range(0, 3) == 0),
               1'($urandom_range(0, 5) == 0), 1'($urandom_range(0, 5) == 0));
      end
    end
    idle();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule